// File: doc/BRIEF.md
# Multiplexed Bus Exchanger, 12-bit to 24-bit

The block couples a narrow 12-bit port (A) to a wide 24-bit port (B). Port B is split into two 12-bit halves, 1B and 2B. Going from A to B, each half has its own edge-triggered register and its own active-low clock enable. Two A words that arrive on two consecutive clock edges can therefore be captured into the two halves and leave together as one 24-bit word on B.

Going from B to A, each half of B feeds its own level-sensitive latch. A half-select input picks which latch drives A. The latches are transparent while their active-low enable is low, so a word read from the wide side reaches the narrow side without waiting for a clock edge.

Each bidirectional port is modelled as an input bus, an output bus and a drive-enable flag, so the block contains no internal tri-state logic. An active-low output enable for each port lowers that port's drive flag and forces its output bus to zero. Reset is synchronous and active high for the registers. For the latches, reset is level-sensitive: they are held at zero for as long as reset is high.

Top module: `bx_exchanger`

## Requirements
- R1: On a rising clock edge with ab_ce_n[0]=0, a_in is loaded into the 1B register, which drives b_out[11:0] after that edge. With ab_ce_n[1]=0, a_in is loaded into the 2B register, which drives b_out[23:12].
- R2: A half whose clock enable is high at a rising edge keeps its previous value.
- R3: Loading word X into 1B on one edge and word Y into 2B on the next edge makes b_out equal {Y, X}.
- R4: While ba_le_n[0]=0, the 1B latch follows b_in[11:0]. While ba_le_n[1]=0, the 2B latch follows b_in[23:12]. A transparent latch that is selected shows a change on b_in at a_out in the same cycle.
- R5: A latch whose enable is high holds its value while b_in changes.
- R6: sel=0 routes the 1B latch to a_out, and sel=1 routes the 2B latch to a_out.
- R7: With oe_a_n=1, a_oe=0 and a_out=0. With oe_a_n=0, a_oe=1 and a_out carries the selected latch.
- R8: With oe_b_n=1, b_oe=0 and b_out=0. With oe_b_n=0, b_oe=1 and b_out carries both registers.
- R9: rst high at a rising edge clears both registers, and rst high clears both latches. After reset, with both outputs enabled and nothing loaded, a_out and b_out read 0.
- R10: With both clock enables low at the same edge, the same A word is loaded into both halves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the A-to-B registers |
| rst | input | 1 | Synchronous active-high reset for the registers; level clear for the latches |
| a_in | input | 12 | Data received on the narrow port |
| a_out | output | 12 | Data driven onto the narrow port (0 when disabled) |
| a_oe | output | 1 | Drive flag for the narrow port |
| b_in | input | 24 | Data received on the wide port; 1B in [11:0], 2B in [23:12] |
| b_out | output | 24 | Data driven onto the wide port (0 when disabled) |
| b_oe | output | 1 | Drive flag for the wide port |
| ab_ce_n | input | 2 | Active-low clock enables; bit 0 for 1B, bit 1 for 2B |
| ba_le_n | input | 2 | Active-low latch enables; bit 0 for 1B, bit 1 for 2B |
| sel | input | 1 | Selects the latch for a_out: 0 chooses 1B, 1 chooses 2B |
| oe_a_n | input | 1 | Active-low output enable of the narrow port |
| oe_b_n | input | 1 | Active-low output enable of the wide port |

## Verification
A wrong register state shows on b_out 2 ns after the rising edge that loads it, provided oe_b_n is low. A stray load into one half corrupts only that half's 12 bits. A wrong latch state is visible at once on a_out, but only while that latch is selected. For this reason every hold test on a latch is read back through the select line after b_in has moved. Errors in the output gating show on the drive flag and on the output bus in the same cycle as the change on the enable.

// File: rtl/bx_pkg.sv
package bx_pkg;
  localparam int unsigned NUM_HALVES = 2;
  typedef enum logic {
    SEL_1B = 1'b0,
    SEL_2B = 1'b1
  } half_sel_e;
endpackage

// File: rtl/bx_ab_reg.sv
module bx_ab_reg #(
  parameter int unsigned HALF_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic [HALF_W-1:0] d,
  output logic [HALF_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (!ce_n) q <= d;
  end

  // R2
  ab_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> $stable(q));
endmodule

// File: rtl/bx_ba_latch.sv
module bx_ba_latch #(
  parameter int unsigned HALF_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              le_n,
  input  logic [HALF_W-1:0] d,
  output logic [HALF_W-1:0] q
);
  always_latch begin
    if (rst) q <= '0;
    else if (!le_n) q <= d;
  end

  // R5
  ba_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (le_n && $past(le_n)) |-> $stable(q));
endmodule

// File: rtl/bx_half_mux.sv
module bx_half_mux #(
  parameter int unsigned HALF_W = 12
) (
  input  bx_pkg::half_sel_e sel,
  input  logic [HALF_W-1:0] h1,
  input  logic [HALF_W-1:0] h2,
  output logic [HALF_W-1:0] y
);
  always_comb begin
    unique case (sel)
      bx_pkg::SEL_2B: y = h2;
      default:        y = h1;
    endcase
  end
endmodule

// File: rtl/bx_exchanger.sv
module bx_exchanger #(
  parameter int unsigned HALF_W = 12,
  localparam int unsigned NH    = bx_pkg::NUM_HALVES,
  localparam int unsigned BUS_W = NH * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HALF_W-1:0] a_in,
  output logic [HALF_W-1:0] a_out,
  output logic              a_oe,
  input  logic [BUS_W-1:0]  b_in,
  output logic [BUS_W-1:0]  b_out,
  output logic              b_oe,
  input  logic [NH-1:0]     ab_ce_n,
  input  logic [NH-1:0]     ba_le_n,
  input  logic              sel,
  input  logic              oe_a_n,
  input  logic              oe_b_n
);
  logic [BUS_W-1:0]  b_q;
  logic [BUS_W-1:0]  lat_q;
  logic [HALF_W-1:0] a_sel;
  bx_pkg::half_sel_e sel_e;

  for (genvar h = 0; h < NH; h++) begin : g_half
    bx_ab_reg #(.HALF_W(HALF_W)) u_reg (
      .clk (clk),
      .rst (rst),
      .ce_n(ab_ce_n[h]),
      .d   (a_in),
      .q   (b_q[h*HALF_W +: HALF_W])
    );
    bx_ba_latch #(.HALF_W(HALF_W)) u_lat (
      .clk (clk),
      .rst (rst),
      .le_n(ba_le_n[h]),
      .d   (b_in[h*HALF_W +: HALF_W]),
      .q   (lat_q[h*HALF_W +: HALF_W])
    );
  end

  assign sel_e = bx_pkg::half_sel_e'(sel);

  bx_half_mux #(.HALF_W(HALF_W)) u_mux (
    .sel(sel_e),
    .h1 (lat_q[0 +: HALF_W]),
    .h2 (lat_q[HALF_W +: HALF_W]),
    .y  (a_sel)
  );

  assign a_oe  = !oe_a_n;
  assign b_oe  = !oe_b_n;
  assign a_out = a_oe ? a_sel : '0;
  assign b_out = b_oe ? b_q : '0;

  // R1
  pack_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (!ab_ce_n[0] && !oe_b_n) |=> (oe_b_n || b_out[HALF_W-1:0] == $past(a_in)));

  // R7
  a_off_chk: assert property (@(posedge clk) disable iff (rst)
    oe_a_n |-> (!a_oe && a_out == '0));

  // R8
  b_off_chk: assert property (@(posedge clk) disable iff (rst)
    oe_b_n |-> (!b_oe && b_out == '0));
endmodule

// File: tb/sim_bx_exchanger.sv
module sim_bx_exchanger;
  localparam int HW = 12;
  localparam int BW = 24;

  typedef struct {
    string         tag;
    logic [HW-1:0] a_exp;
    logic          aoe_exp;
    logic [BW-1:0] b_exp;
    logic          boe_exp;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [HW-1:0] a_in = '0;
  logic [HW-1:0] a_out;
  logic a_oe;
  logic [BW-1:0] b_in = '0;
  logic [BW-1:0] b_out;
  logic b_oe;
  logic [1:0] ab_ce_n = 2'b11;
  logic [1:0] ba_le_n = 2'b11;
  logic sel = 1'b0;
  logic oe_a_n = 1'b1;
  logic oe_b_n = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  item_t sb[$];

  logic [HW-1:0] m_r1 = '0, m_r2 = '0, m_l1 = '0, m_l2 = '0;

  always #5 clk = ~clk;

  bx_exchanger u0 (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ab_ce_n(ab_ce_n),
    .ba_le_n(ba_le_n), .sel(sel), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n)
  );

  task automatic step(input string tag, input logic r, input logic [HW-1:0] a,
                      input logic [BW-1:0] b, input logic [1:0] ce, input logic [1:0] le,
                      input logic s, input logic oa, input logic ob);
    item_t it;
    @(negedge clk);
    rst = r; a_in = a; b_in = b; ab_ce_n = ce; ba_le_n = le;
    sel = s; oe_a_n = oa; oe_b_n = ob;
    if (r) begin
      m_r1 = '0; m_r2 = '0; m_l1 = '0; m_l2 = '0;
    end else begin
      if (!ce[0]) m_r1 = a;
      if (!ce[1]) m_r2 = a;
      if (!le[0]) m_l1 = b[HW-1:0];
      if (!le[1]) m_l2 = b[BW-1:HW];
    end
    it.tag = tag;
    it.aoe_exp = !oa;
    it.boe_exp = !ob;
    it.a_exp = oa ? '0 : (s ? m_l2 : m_l1);
    it.b_exp = ob ? '0 : {m_r2, m_r1};
    sb.push_back(it);
  endtask

  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_cmp++;
      if (a_out !== it.a_exp || a_oe !== it.aoe_exp ||
          b_out !== it.b_exp || b_oe !== it.boe_exp) begin
        n_bad++;
        $display("FAIL %s: a_out=%h a_oe=%b b_out=%h b_oe=%b expected a_out=%h a_oe=%b b_out=%h b_oe=%b",
                 it.tag, a_out, a_oe, b_out, b_oe,
                 it.a_exp, it.aoe_exp, it.b_exp, it.boe_exp);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R9 reset, then outputs enabled with nothing loaded
    step("R9 reset", 1, 12'hFFF, 24'hABCDEF, 2'b00, 2'b00, 0, 0, 0);
    step("R9 reset hold", 1, 12'h123, 24'h123456, 2'b00, 2'b00, 1, 0, 0);
    step("R9 after reset", 0, 12'h555, 24'h0, 2'b11, 2'b11, 0, 0, 0);
    // R8 disabled B port
    step("R8 b off", 0, 12'h0, 24'h0, 2'b11, 2'b11, 0, 0, 1);
    // R1 load 1B / R3 pack
    step("R1 load 1B", 0, 12'hA5C, 24'h0, 2'b10, 2'b11, 0, 0, 0);
    step("R3 pack 2B", 0, 12'h3E7, 24'h0, 2'b01, 2'b11, 0, 0, 0);
    // R2 hold both halves
    step("R2 hold", 0, 12'hFFF, 24'h0, 2'b11, 2'b11, 0, 0, 0);
    step("R1 reload 1B", 0, 12'h001, 24'h0, 2'b10, 2'b11, 0, 0, 0);
    // R10 both at once
    step("R10 both", 0, 12'h9B2, 24'h0, 2'b00, 2'b11, 0, 0, 0);
    // R8 disable then re-enable keeps contents
    step("R8 off again", 0, 12'h000, 24'h0, 2'b11, 2'b11, 0, 0, 1);
    step("R8 on again", 0, 12'h000, 24'h0, 2'b11, 2'b11, 0, 0, 0);
    // R4 transparency, R6 select
    step("R4 1B transparent", 0, 12'h0, 24'h654321, 2'b11, 2'b10, 0, 0, 0);
    step("R4 1B follows", 0, 12'h0, 24'h654ABC, 2'b11, 2'b10, 0, 0, 0);
    step("R4 2B transparent", 0, 12'h0, 24'h789ABC, 2'b11, 2'b01, 1, 0, 0);
    step("R6 sel 1B", 0, 12'h0, 24'h789ABC, 2'b11, 2'b11, 0, 0, 0);
    step("R6 sel 2B", 0, 12'h0, 24'h789ABC, 2'b11, 2'b11, 1, 0, 0);
    // R5 hold while b_in moves
    step("R5 hold 2B", 0, 12'h0, 24'h111222, 2'b11, 2'b11, 1, 0, 0);
    step("R5 hold 1B", 0, 12'h0, 24'h333444, 2'b11, 2'b11, 0, 0, 0);
    step("R5 2B open 1B held", 0, 12'h0, 24'hDEF000, 2'b11, 2'b01, 0, 0, 0);
    step("R6 read 2B", 0, 12'h0, 24'h000000, 2'b11, 2'b11, 1, 0, 0);
    // R7 A port gating
    step("R7 a off", 0, 12'h0, 24'h0, 2'b11, 2'b11, 1, 1, 0);
    step("R7 a on", 0, 12'h0, 24'h0, 2'b11, 2'b11, 1, 0, 0);
    // both directions at once
    step("R1 R4 concurrent", 0, 12'h7F0, 24'hC0FFEE, 2'b10, 2'b00, 1, 0, 0);
    step("R3 second word", 0, 12'h0E1, 24'hC0FFEE, 2'b01, 2'b11, 0, 0, 0);
    // R9 reset again clears everything
    step("R9 reset again", 1, 12'h0, 24'h0, 2'b11, 2'b11, 0, 0, 0);
    step("R9 cleared 2B", 0, 12'h0, 24'h0, 2'b11, 2'b11, 1, 0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule